// File: doc/BRIEF.md
# Message Sequence and Channel Watchdog

This block supervises one receive channel over which a remote terminal sends periodic measurement messages, each tagged with a 4-bit sequence number. Each arriving message is compared with the number that should come next, modulo 16. A mismatch means that messages went missing. The block reports how many were missed, and it adds that number to a running count of consecutive losses.

The channel is declared failed in either of two cases. The first is when the consecutive-loss count reaches a configured limit. That limit is capped at 15, so a run of losses never wraps the sequence space and messages can still be matched. The second is when a tick-driven watchdog sees the interval since the last arrival exceed a configured number of ticks.

A failure takes the channel out of service, raises a sticky failed flag and pulses a recovery-start strobe. The next message to arrive puts the channel back in service and synchronises the expected sequence number to it.

Top module: `chan_seq_monitor`

## Requirements
- R1: After reset, `in_service`, `chan_failed`, `lost_pulse`, `recovery_start` and `lost_count` are all 0.
- R2: A message that arrives while the channel is out of service sets `in_service` and clears `chan_failed` on the following cycle. It reports no loss, and the next expected sequence number becomes its number plus 1, modulo 16.
- R3: A message whose number equals the expected number gives `lost_pulse`=0 and `lost_count`=0, and it clears the consecutive-loss count. The expected number after 15 is 0.
- R4: An in-service message whose number differs from the expected one gives `lost_pulse`=1 for one cycle. On that cycle `lost_count` equals (received − expected) mod 16, which is the number of messages skipped. On all other cycles `lost_count` is 0.
- R5: Gaps add to the consecutive-loss count until an in-sequence message clears it. Failure is declared on the message that brings the count to or above the effective limit.
- R6: The effective loss limit is `cfg_loss_limit` clamped to the range 1..15. Values above 15 act as 15, and 0 acts as 1.
- R7: While in service, the block counts `tick` pulses since the last message. The tick that arrives when the count already equals `cfg_wd_limit` declares failure, so up to `cfg_wd_limit` ticks may pass with no message.
- R8: A failure sets `chan_failed`=1 and `in_service`=0 on the next cycle, and `recovery_start` is 1 for exactly that one cycle.
- R9: When a message and a tick arrive in the same cycle, the message takes precedence: no watchdog failure occurs and the tick count restarts from 0.
- R10: While the channel is out of service and no message arrives, ticks have no effect and `chan_failed` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_valid | input | 1 | One-cycle strobe for an arriving message |
| msg_seq | input | 4 | Sequence number of the arriving message |
| tick | input | 1 | Timebase pulse for the watchdog |
| cfg_loss_limit | input | 5 | Consecutive-loss limit (clamped to 1..15) |
| cfg_wd_limit | input | 12 | Maximum number of ticks allowed between messages |
| lost_pulse | output | 1 | A sequence gap was seen |
| lost_count | output | 4 | Number of messages missed in that gap |
| in_service | output | 1 | The channel is in service |
| chan_failed | output | 1 | Channel failure has been declared |
| recovery_start | output | 1 | One-cycle pulse when failure is declared |

## Verification
Two things can fall in the same cycle: a message arriving and the watchdog tick that would otherwise expire the interval. The bench lets the tick count reach its limit and then drives a message together with a tick. It judges that the channel stays in service and that the full watchdog window restarts from that cycle. A gapped message can also end the loss run on the very message that reports the gap. In that case `lost_pulse`, the correct `lost_count` and a single `recovery_start` must appear together on one cycle. The bench provokes this by sweeping every gap from every starting number, and by sweeping all 32 limit settings against a steady stream of single gaps.

// File: rtl/chan_seq_monitor.sv
module chan_seq_monitor #(
  parameter int SEQ_W = 4,
  parameter int LIM_W = 5,
  parameter int WD_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_valid,
  input  logic [SEQ_W-1:0] msg_seq,
  input  logic             tick,
  input  logic [LIM_W-1:0] cfg_loss_limit,
  input  logic [WD_W-1:0]  cfg_wd_limit,
  output logic             lost_pulse,
  output logic [SEQ_W-1:0] lost_count,
  output logic             in_service,
  output logic             chan_failed,
  output logic             recovery_start
);
  localparam int SPAN  = (1 << SEQ_W) - 1;
  localparam int RUN_W = SEQ_W + 1;

  logic [SEQ_W-1:0] exp_seq, gap, lim_eff;
  logic [RUN_W-1:0] run, run_next;
  logic [WD_W-1:0]  wd_cnt;
  logic             accept, loss_fail, wd_fail;

  assign lim_eff   = (cfg_loss_limit > LIM_W'(SPAN)) ? SEQ_W'(SPAN) :
                     (cfg_loss_limit == '0) ? SEQ_W'(1) : cfg_loss_limit[SEQ_W-1:0];
  assign gap       = msg_seq - exp_seq;
  assign run_next  = run + {1'b0, gap};
  assign accept    = in_service && msg_valid;
  assign loss_fail = accept && (gap != '0) && (run_next >= {1'b0, lim_eff});
  assign wd_fail   = in_service && !msg_valid && tick && (wd_cnt == cfg_wd_limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_seq        <= '0;
      run            <= '0;
      wd_cnt         <= '0;
      in_service     <= 1'b0;
      chan_failed    <= 1'b0;
      lost_pulse     <= 1'b0;
      lost_count     <= '0;
      recovery_start <= 1'b0;
    end else begin
      lost_pulse     <= accept && (gap != '0);
      lost_count     <= accept ? gap : '0;
      recovery_start <= loss_fail || wd_fail;
      if (msg_valid) begin
        exp_seq <= msg_seq + 1'b1;
        wd_cnt  <= '0;
      end
      if (!in_service) begin
        if (msg_valid) begin
          in_service  <= 1'b1;
          chan_failed <= 1'b0;
          run         <= '0;
        end
      end else if (loss_fail || wd_fail) begin
        in_service  <= 1'b0;
        chan_failed <= 1'b1;
        run         <= '0;
        wd_cnt      <= '0;
      end else if (msg_valid) begin
        run <= (gap == '0) ? '0 : run_next;
      end else if (tick) begin
        wd_cnt <= wd_cnt + 1'b1;
      end
    end
  end

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_service && chan_failed));
  a_r8_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    recovery_start |-> ($rose(chan_failed) && $fell(in_service)));
  a_r4_count: assert property (@(posedge clk) disable iff (!rst_n)
    lost_pulse |-> (lost_count != '0));
  a_r2_enter: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !in_service) |=> (in_service && !chan_failed && !lost_pulse));
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_service && !msg_valid) |=> (!in_service && $stable(chan_failed) && !recovery_start));
  a_r9_precedence: assert property (@(posedge clk) disable iff (!rst_n)
    (in_service && msg_valid && tick && !loss_fail) |=> in_service);
endmodule

// File: tb/chan_seq_monitor_test.sv
module chan_seq_monitor_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        msg_valid = 1'b0, tick = 1'b0;
  logic [3:0]  msg_seq = '0;
  logic [4:0]  cfg_loss_limit = 5'd15;
  logic [11:0] cfg_wd_limit = 12'd4095;
  logic        lost_pulse, in_service, chan_failed, recovery_start;
  logic [3:0]  lost_count;

  int n_tests = 0, n_fail = 0;
  int m_in, m_failed, m_exp, m_run, m_wd, m_eff, m_wdlim;
  bit done = 0;

  chan_seq_monitor uut (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_seq(msg_seq), .tick(tick),
    .cfg_loss_limit(cfg_loss_limit), .cfg_wd_limit(cfg_wd_limit),
    .lost_pulse(lost_pulse), .lost_count(lost_count), .in_service(in_service),
    .chan_failed(chan_failed), .recovery_start(recovery_start));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string tag, string what, int got, int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic do_reset(int lim, int wdl);
    @(negedge clk);
    msg_valid = 0; tick = 0; rst_n = 0;
    cfg_loss_limit = lim[4:0]; cfg_wd_limit = wdl[11:0];
    m_eff = (lim > 15) ? 15 : ((lim == 0) ? 1 : lim);
    m_wdlim = wdl;
    m_in = 0; m_failed = 0; m_exp = 0; m_run = 0; m_wd = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
  endtask

  task automatic step(bit v, int s, bit tk, string tag);
    int elp = 0, elc = 0, erec = 0, gap;
    bit fail = 0;
    @(negedge clk);
    msg_valid = v; msg_seq = s[3:0]; tick = tk;
    if (m_in != 0) begin
      if (v) begin
        gap = (s - m_exp) & 15;
        elp = (gap != 0); elc = gap;
        if (gap == 0) m_run = 0;
        else begin m_run += gap; if (m_run >= m_eff) fail = 1; end
        m_wd = 0; m_exp = (s + 1) & 15;
      end else if (tk) begin
        if (m_wd == m_wdlim) fail = 1; else m_wd++;
      end
      if (fail) begin m_in = 0; m_failed = 1; erec = 1; m_run = 0; m_wd = 0; end
    end else if (v) begin
      m_in = 1; m_failed = 0; m_run = 0; m_wd = 0; m_exp = (s + 1) & 15;
    end
    @(posedge clk); #1;
    chk(tag, "lost_pulse", int'(lost_pulse), elp);
    chk(tag, "lost_count", int'(lost_count), elc);
    chk(tag, "in_service", int'(in_service), m_in);
    chk(tag, "chan_failed", int'(chan_failed), m_failed);
    chk(tag, "recovery_start", int'(recovery_start), erec);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not finish, got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int s;
    // R1 reset state, R10 ticks ignored while idle
    do_reset(15, 4);
    #1;
    chk("R1", "in_service", int'(in_service), 0);
    chk("R1", "chan_failed", int'(chan_failed), 0);
    chk("R1", "recovery_start", int'(recovery_start), 0);
    chk("R1", "lost_count", int'(lost_count), 0);
    for (int i = 0; i < 10; i++) step(0, 0, 1, "R10");
    step(1, 9, 0, "R2");

    // R6 sweep of every limit setting with a stream of single gaps
    for (int c = 0; c < 32; c++) begin
      do_reset(c, 4095);
      s = c & 15;
      step(1, s, 0, "R2");
      for (int k = 0; k < 20; k++) begin
        s = (s + 2) & 15;
        step(1, s, 0, "R6");
      end
    end

    // R4 / R3 every gap from every start, limit 15
    do_reset(31, 4095);
    for (int st = 0; st < 16; st++)
      for (int g = 0; g < 16; g++) begin
        step(1, st, 0, "R2");
        step(1, (st + 1 + g) & 15, 0, "R4");
        step(1, (st + 2 + g) & 15, 0, "R3");
      end

    // R5 accumulation and clearing, limit 6
    do_reset(6, 4095);
    step(1, 0, 0, "R2");
    step(1, 3, 0, "R5");
    step(1, 6, 0, "R5");
    step(1, 7, 0, "R5");
    step(1, 10, 0, "R5");
    step(1, 13, 0, "R5");
    step(1, 0, 0, "R5");
    chk("R5", "failed after run 6", int'(chan_failed), 1);

    // R8 single gap with limit 1
    do_reset(1, 4095);
    step(1, 4, 0, "R2");
    step(1, 6, 0, "R8");
    chk("R8", "recovery_start", int'(recovery_start), 1);
    step(0, 0, 0, "R8");
    step(1, 8, 0, "R2");

    // R7 watchdog boundary sweep
    for (int w = 0; w < 8; w++) begin
      do_reset(15, w);
      step(1, w, 0, "R2");
      for (int t = 0; t <= w; t++) begin
        step(0, 0, 0, "R7");
        step(0, 0, 1, "R7");
      end
      chk("R7", "failed after limit", int'(chan_failed), 1);
      for (int t = 0; t < 5; t++) step(0, 0, 1, "R10");
    end

    // R9 message and tick together
    do_reset(15, 3);
    step(1, 2, 0, "R2");
    for (int t = 0; t < 3; t++) step(0, 0, 1, "R9");
    step(1, 3, 1, "R9");
    chk("R9", "in_service", int'(in_service), 1);
    for (int t = 0; t < 4; t++) step(0, 0, 1, "R9");
    step(1, 0, 0, "R2");
    for (int t = 0; t < 3; t++) step(0, 0, 1, "R9");
    step(1, 9, 1, "R9");
    for (int t = 0; t < 3; t++) step(0, 0, 1, "R9");
    step(1, 11, 1, "R9");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule